// File: doc/BRIEF.md
# Key-Gated Scratch SRAM Eraser with Page Write Protection

This block guards a tightly coupled scratch SRAM that is split into pages of equal size. Software can wipe the whole array with a hardware erase, but only after it writes a two-byte unlock code to a write-only key register. Once started, the erase engine writes zero to every word, one word per clock, from address 0 up to the last word. While it runs, a busy status bit is set, the erase request bit reads as set, and CPU writes are held off with a stall signal. When the last word is written, both bits clear without any software action. Each successful start uses up the unlock, so the next erase needs the key again.

A protect register holds one bit per page. Software can set these bits but never clear them; only reset clears them. A CPU write that falls in a protected page is dropped, and the block answers it with a violation pulse. The erase engine does not look at page protection. The SRAM storage sits inside the block, with a depth set by a parameter. The write port that feeds the storage is also driven out of the block, so neighbours can observe it. A combinational read port returns the stored contents.

Top module: `ccsram_guard`

## Requirements
- R1: After reset, the control/status register (index 0), the protect register (index 1) and the key register (index 2) all read 0, and `cpu_stall` and `cpu_viol` are 0.
- R2: Software first writes 0xCA and then 0x53 to bits 7:0 of the key register. A following control write with bit 0 set then starts an erase, and from the next cycle the control register reads 0x3 (bit 0 = erase request, bit 1 = busy).
- R3: A control write with bit 0 set while the key sequence is not complete is ignored. The control register stays 0 and stored words are unchanged.
- R4: After 0xCA, any key value other than 0x53 (0xCA included) locks the block again. A value other than 0xCA written while locked also leaves it locked. In both cases a later 0x53 alone does not unlock it.
- R5: An erase keeps busy set for exactly WORDS cycles. In each of those cycles the SRAM write port writes 0 to the next address, from 0 up to WORDS-1. After that, the control register reads 0.
- R6: One successful start uses up the unlock. A second start without a new key sequence is ignored.
- R7: A write to the protect register ORs its data into the stored bits. Writing 0 clears nothing, and only reset returns the register to 0.
- R8: A CPU write whose page, given by address bits ADDR_W-1 down to ADDR_W-PAGE_W, has its protect bit set is dropped. `cpu_viol` goes high for one cycle, in the cycle after the request. A CPU write to an unprotected page is stored, and `cpu_viol` stays 0.
- R9: While an erase runs, `cpu_stall` is 1, CPU write requests are neither performed nor flagged, and the erase zeroes protected pages as well.
- R10: The key register always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control/status, 1 protect, 2 key |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_wr | input | 1 | CPU SRAM write request |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_stall | output | 1 | CPU write held off because an erase is running |
| cpu_viol | output | 1 | One-cycle pulse after a write to a protected page |
| rd_addr | input | ADDR_W | Read port word address |
| rd_data | output | DATA_W | Read port data (combinational) |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM write address |
| sram_wdata | output | DATA_W | SRAM write data |

## Verification
The bench attacks the key handshake with near misses: 0xCA written twice, a stray byte between the two key values, and 0x53 written alone. A design that only compared the last byte written would unlock on these and start an erase that software never asked for. It times the erase exactly and follows the write port word by word. An off-by-one counter would either leave the top word holding data or drop busy one cycle early. It also writes zeros to the protect register and aims stalled and protected writes at pages. A design that cleared protect bits, let a stalled write slip through, or skipped protected pages during the erase would leave stale data that the read port shows.

// File: rtl/ccsram_guard_pkg.sv
package ccsram_guard_pkg;

   localparam int REG_W = 32;

   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_PROT = 2'd1;
   localparam logic [1:0] IDX_KEY  = 2'd2;

   localparam int CTRL_REQ_BIT  = 0;
   localparam int CTRL_BUSY_BIT = 1;

   typedef enum logic [1:0] {
      KEY_LOCKED = 2'd0,
      KEY_HALF   = 2'd1,
      KEY_OPEN   = 2'd2
   } key_state_e;

endpackage

// File: rtl/ccsram_keylock.sv
module ccsram_keylock
   import ccsram_guard_pkg::*;
#(
   parameter logic [7:0] CODE_A = 8'hCA,
   parameter logic [7:0] CODE_B = 8'h53
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       consume,
   output logic       unlocked
);

   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (consume) begin
         state_d = KEY_LOCKED;
      end else if (key_wr) begin
         if (key_byte == CODE_A && state_q != KEY_HALF)
            state_d = KEY_HALF;
         else if (key_byte == CODE_B && state_q == KEY_HALF)
            state_d = KEY_OPEN;
         else
            state_d = KEY_LOCKED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KEY_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KEY_OPEN);

endmodule

// File: rtl/ccsram_eraser.sv
module ccsram_eraser #(
   parameter int WORDS  = 256,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [ADDR_W-1:0] waddr
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

   logic              busy_q;
   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end
   end

   assign busy  = busy_q;
   assign waddr = cnt_q;

endmodule

// File: rtl/ccsram_protect.sv
module ccsram_protect #(
   parameter int WORDS  = 256,
   parameter int PAGES  = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wr,
   input  logic [PAGES-1:0]  set_bits,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              hold,
   output logic [PAGES-1:0]  prot,
   output logic              accept,
   output logic              viol
);

   localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;

   logic [PAGES-1:0] prot_q;
   logic             viol_q;
   logic [PAGE_W-1:0] page;
   logic             hit;

   generate
      if (PAGES > 1) begin : g_multi
         assign page = cpu_addr[ADDR_W-1 -: PAGE_W];
      end else begin : g_single
         assign page = '0;
      end
   endgenerate

   assign hit    = prot_q[page];
   assign accept = cpu_wr && !hold && !hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q <= '0;
         viol_q <= 1'b0;
      end else begin
         if (set_wr) prot_q <= prot_q | set_bits;
         viol_q <= cpu_wr && !hold && hit;
      end
   end

   assign prot = prot_q;
   assign viol = viol_q;

endmodule

// File: rtl/ccsram_store.sv
module ccsram_store #(
   parameter int WORDS  = 256,
   parameter int DATA_W = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/ccsram_guard.sv
module ccsram_guard
   import ccsram_guard_pkg::*;
#(
   parameter int         WORDS  = 256,
   parameter int         PAGES  = 32,
   parameter int         DATA_W = 32,
   parameter logic [7:0] CODE_A = 8'hCA,
   parameter logic [7:0] CODE_B = 8'h53,
   parameter int         ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_stall,
   output logic              cpu_viol,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              sram_we,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_wdata
);

   generate
      if (PAGES < 1 || PAGES > REG_W || (PAGES & (PAGES - 1)) != 0)
         $error("PAGES must be a power of two between 1 and 32");
      if (WORDS < 2 * PAGES || (WORDS & (WORDS - 1)) != 0)
         $error("WORDS must be a power of two of at least twice PAGES");
      if (ADDR_W != $clog2(WORDS))
         $error("ADDR_W must match WORDS");
   endgenerate

   logic             busy;
   logic             key_open;
   logic             start;
   logic             accept;
   logic [PAGES-1:0] prot;
   logic [ADDR_W-1:0] erase_addr;

   wire ctrl_wr = reg_wr && (reg_addr == IDX_CTRL);
   wire prot_wr = reg_wr && (reg_addr == IDX_PROT);
   wire key_wr  = reg_wr && (reg_addr == IDX_KEY);

   assign start = ctrl_wr && reg_wdata[CTRL_REQ_BIT] && key_open && !busy;

   ccsram_keylock #(
      .CODE_A (CODE_A),
      .CODE_B (CODE_B)
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_byte (reg_wdata[7:0]),
      .consume  (start),
      .unlocked (key_open)
   );

   ccsram_eraser #(
      .WORDS  (WORDS),
      .ADDR_W (ADDR_W)
   ) u_erase (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .waddr (erase_addr)
   );

   ccsram_protect #(
      .WORDS  (WORDS),
      .PAGES  (PAGES),
      .ADDR_W (ADDR_W)
   ) u_prot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wr   (prot_wr),
      .set_bits (reg_wdata[PAGES-1:0]),
      .cpu_wr   (cpu_wr),
      .cpu_addr (cpu_addr),
      .hold     (busy),
      .prot     (prot),
      .accept   (accept),
      .viol     (cpu_viol)
   );

   assign sram_we    = busy | accept;
   assign sram_addr  = busy ? erase_addr : cpu_addr;
   assign sram_wdata = busy ? '0 : cpu_wdata;
   assign cpu_stall  = busy;

   ccsram_store #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk   (clk),
      .we    (sram_we),
      .waddr (sram_addr),
      .wdata (sram_wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         IDX_CTRL: begin
            reg_rdata[CTRL_REQ_BIT]  = busy;
            reg_rdata[CTRL_BUSY_BIT] = busy;
         end
         IDX_PROT: reg_rdata = REG_W'(prot);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ccsram_guard_chk.sv
module ccsram_guard_chk #(
   parameter int WORDS  = 256,
   parameter int PAGES  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              key_open,
   input logic [PAGES-1:0]  prot,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_viol,
   input logic              sram_we,
   input logic [ADDR_W-1:0] sram_addr,
   input logic [DATA_W-1:0] sram_wdata
);

   localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;
   localparam int CNT_W  = ADDR_W + 2;

   logic [CNT_W-1:0] run_cnt;
   logic [PAGE_W-1:0] pg;

   generate
      if (PAGES > 1) begin : g_pg
         assign pg = cpu_addr[ADDR_W-1 -: PAGE_W];
      end else begin : g_pg1
         assign pg = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R2: an erase starts only from the unlocked state
   a_r2_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(key_open));

   // R6: the start uses up the unlock
   a_r6_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !key_open);

   // R5: the busy window lasts exactly WORDS cycles
   a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == CNT_W'(WORDS)));

   // R5: the erase writes zero to consecutive addresses
   a_r5_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sram_we && sram_wdata == '0));

   a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (sram_addr == $past(sram_addr) + 1'b1));

   // R7: protect bits never clear
   a_r7_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(prot) & ~prot) == '0));

   // R8: a write to a protected page is dropped and flagged next cycle
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !busy && prot[pg]) |-> !sram_we);

   a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !busy && prot[pg]) |=> cpu_viol);

   // R9: no violation is raised for a stalled request
   a_r9_no_flag_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wr || busy) |=> !cpu_viol);

endmodule

bind ccsram_guard ccsram_guard_chk #(
   .WORDS  (WORDS),
   .PAGES  (PAGES),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .key_open   (key_open),
   .prot       (prot),
   .cpu_wr     (cpu_wr),
   .cpu_addr   (cpu_addr),
   .cpu_viol   (cpu_viol),
   .sram_we    (sram_we),
   .sram_addr  (sram_addr),
   .sram_wdata (sram_wdata)
);

// File: tb/ccsram_guard_tb.sv
module ccsram_guard_tb;

   localparam int WORDS  = 256;
   localparam int PAGES  = 32;
   localparam int DATA_W = 32;
   localparam int ADDR_W = $clog2(WORDS);
   localparam int WPP    = WORDS / PAGES;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = 2'd0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              cpu_wr = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_stall;
   logic              cpu_viol;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              sram_we;
   logic [ADDR_W-1:0] sram_addr;
   logic [DATA_W-1:0] sram_wdata;

   int n_vec = 0;
   int n_bad = 0;

   logic [DATA_W-1:0] bm [WORDS];
   logic [31:0]       mprot = '0;
   int                mkey  = 0;

   always #2 clk = ~clk;

   ccsram_guard u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .cpu_wr     (cpu_wr),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_stall  (cpu_stall),
      .cpu_viol   (cpu_viol),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .sram_we    (sram_we),
      .sram_addr  (sram_addr),
      .sram_wdata (sram_wdata)
   );

   function automatic int key_next(int k, logic [7:0] b);
      if (b == 8'hCA && k != 1) return 1;
      if (b == 8'h53 && k == 1) return 2;
      return 0;
   endfunction

   function automatic int page_of(logic [ADDR_W-1:0] a);
      return int'(a) / WPP;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 2'd2) mkey = key_next(mkey, d[7:0]);
      if (a == 2'd1) mprot = mprot | d;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic mem_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic cpu_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      logic exp_v;
      exp_v = mprot[page_of(a)];
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
      #1;
      chk("R8 violation pulse", {31'd0, cpu_viol}, {31'd0, exp_v});
      @(negedge clk);
      #1;
      chk("R8 violation ends", {31'd0, cpu_viol}, 32'd0);
      if (!exp_v) bm[a] = d;
   endtask

   // Erase already requested; follow it word by word.
   task automatic follow_erase(bit poke, logic [ADDR_W-1:0] pa, logic [DATA_W-1:0] pd);
      logic [31:0] s;
      reg_read(2'd0, s);
      chk("R2 status after start", s, 32'h3);
      for (int k = 0; k < WORDS; k++) begin
         if (k != 0) #1;
         chk("R5 erase write enable", {31'd0, sram_we}, 32'd1);
         chk("R5 erase address", 32'(sram_addr), 32'(k));
         chk("R5 erase data", sram_wdata, 32'd0);
         if (poke && k >= 5 && k < 10) begin
            chk("R9 stall", {31'd0, cpu_stall}, 32'd1);
            chk("R9 no violation while stalled", {31'd0, cpu_viol}, 32'd0);
         end
         if (poke && k == 4) begin
            cpu_wr = 1'b1; cpu_addr = pa; cpu_wdata = pd;
         end
         if (poke && k == 9) cpu_wr = 1'b0;
         @(negedge clk);
      end
      #1;
      reg_read(2'd0, s);
      chk("R5 status after erase", s, 32'h0);
      for (int i = 0; i < WORDS; i++) bm[i] = '0;
      mkey = 0;
   endtask

   task automatic try_start(bit expect_go);
      logic [31:0] s;
      reg_write(2'd0, 32'h1);
      if (expect_go) begin
         follow_erase(1'b0, '0, '0);
      end else begin
         reg_read(2'd0, s);
         chk("R3 start ignored while locked", s, 32'h0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0]       s;
      logic [DATA_W-1:0] d;
      void'($urandom(32'h1f3a_5c07));
      for (int i = 0; i < WORDS; i++) bm[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_read(2'd0, s); chk("R1 control at reset", s, 32'h0);
      reg_read(2'd1, s); chk("R1 protect at reset", s, 32'h0);
      reg_read(2'd2, s); chk("R1 key at reset", s, 32'h0);
      chk("R1 stall at reset", {31'd0, cpu_stall}, 32'd0);
      chk("R1 violation at reset", {31'd0, cpu_viol}, 32'd0);

      // R8 unprotected writes stored
      cpu_write('0, 32'hA5A5_0001);
      cpu_write(ADDR_W'(WORDS / 2), 32'hA5A5_0002);
      cpu_write(ADDR_W'(WORDS - 1), 32'hA5A5_0003);
      mem_read('0, d); chk("R8 unprotected stored", d, 32'hA5A5_0001);

      // R3 start while locked
      try_start(1'b0);
      mem_read(ADDR_W'(WORDS - 1), d); chk("R3 memory untouched", d, 32'hA5A5_0003);

      // R4 near-miss sequences
      reg_write(2'd2, 32'hCA); reg_write(2'd2, 32'h11); reg_write(2'd2, 32'h53);
      reg_read(2'd0, s);
      try_start(1'b0);
      reg_write(2'd2, 32'hCA); reg_write(2'd2, 32'hCA); reg_write(2'd2, 32'h53);
      reg_write(2'd0, 32'h1);
      reg_read(2'd0, s); chk("R4 double first byte stays locked", s, 32'h0);
      reg_write(2'd2, 32'h53);
      reg_write(2'd0, 32'h1);
      reg_read(2'd0, s); chk("R4 lone second byte stays locked", s, 32'h0);

      // R2 / R5 full erase
      reg_write(2'd2, 32'hCA);
      reg_read(2'd2, s); chk("R10 key reads zero", s, 32'h0);
      reg_write(2'd2, 32'h53);
      reg_write(2'd0, 32'h1);
      follow_erase(1'b0, '0, '0);
      mem_read('0, d);                   chk("R5 first word zeroed", d, 32'h0);
      mem_read(ADDR_W'(WORDS - 1), d);   chk("R5 last word zeroed", d, 32'h0);

      // R6 unlock consumed
      reg_write(2'd0, 32'h1);
      reg_read(2'd0, s); chk("R6 second start ignored", s, 32'h0);

      // R7 set-only protection
      reg_write(2'd1, 32'h5);
      reg_read(2'd1, s); chk("R7 protect set", s, 32'h5);
      cpu_write(ADDR_W'(9 * WPP + 2), 32'hDEAD_0009);
      reg_write(2'd1, 32'h200);
      reg_read(2'd1, s); chk("R7 protect accumulates", s, 32'h205);
      reg_write(2'd1, 32'h0);
      reg_read(2'd1, s); chk("R7 zero write clears nothing", s, 32'h205);

      // R8 protected pages
      cpu_write(ADDR_W'(3), 32'h1111_2222);
      mem_read(ADDR_W'(3), d); chk("R8 protected write dropped", d, 32'h0);
      cpu_write(ADDR_W'(WPP + 1), 32'h3333_4444);
      mem_read(ADDR_W'(WPP + 1), d); chk("R8 unprotected write stored", d, 32'h3333_4444);
      cpu_write(ADDR_W'(9 * WPP + 2), 32'h5555_6666);
      mem_read(ADDR_W'(9 * WPP + 2), d); chk("R8 protected page keeps old data", d, 32'hDEAD_0009);

      // R9 erase with a stalled write and a protected page holding data
      reg_write(2'd2, 32'hCA); reg_write(2'd2, 32'h53);
      reg_write(2'd0, 32'h1);
      follow_erase(1'b1, ADDR_W'(WPP + 3), 32'h7777_8888);
      mem_read(ADDR_W'(WPP + 3), d);     chk("R9 stalled write not performed", d, 32'h0);
      mem_read(ADDR_W'(9 * WPP + 2), d); chk("R9 protected page erased", d, 32'h0);

      // Random phase
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 8);
         if (op <= 2) begin
            cpu_write(ADDR_W'($urandom), $urandom | 32'h1);
         end else if (op == 3) begin
            int c;
            logic [7:0] b;
            c = int'($urandom % 3);
            b = (c == 0) ? 8'hCA : (c == 1) ? 8'h53 : 8'($urandom);
            reg_write(2'd2, {24'd0, b});
         end else if (op == 4) begin
            bit go;
            go = (mkey == 2);
            reg_write(2'd0, 32'h1);
            if (go) follow_erase(1'b0, '0, '0);
            else begin
               reg_read(2'd0, s); chk("R3 random locked start", s, 32'h0);
            end
         end else if (op == 5) begin
            if ($urandom % 4 == 0) reg_write(2'd1, 32'h1 << ($urandom % 32));
            else reg_write(2'd1, 32'h0);
            reg_read(2'd1, s); chk("R7 random protect", s, mprot);
         end else begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            mem_read(a, d); chk("R8 random readback", d, bm[a]);
            reg_read(2'd2, s); chk("R10 random key read", s, 32'h0);
         end
      end

      // R7 reset clears protection
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(2'd1, s); chk("R7 reset clears protect", s, 32'h0);
      reg_read(2'd0, s); chk("R1 control after reset", s, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule